// File: doc/BRIEF.md
# Flash Program and Erase Controller

This block programs and erases an on-chip flash array that is modelled here as a bank of word registers. Software talks to it over a small register bus. It sets a write-enable bit, places a target word address in a staging register, loads that address into a working pointer with a command, and then either programs one word, streams words through a self-advancing pointer, or erases a whole page. Programming can only clear bits, so a programmed word becomes the old contents ANDed with the new data. An erase returns every word of a page to all ones.

Each page has a protection bit. The protection bits sit in an extra page placed after the main pages, called the lock page. Word k of the lock page holds the bits for pages 32k to 32k+31, and bit p of the packed vector belongs to page p. The lock page is protected by its own bit, at the index equal to the number of main pages. That protection is overridden while the debug-mode input is high. A separate combinational read port returns any array word, and the busy, ready and error flags are also brought out as ports.

With the default parameters there are 8 main pages of 16 words, and the lock page covers word addresses 128 to 143. A program takes 8 cycles and an erase takes 20.

Top module: `flashctl`

## Requirements
- R1: After reset, busy is 0, wdata_ready is 1, err is 0, the pointer register (offset 5) reads 0 and every array word reads 0xFFFFFFFF.
- R2: When the write-enable bit (bit 0 of the control register, offset 0) is 0, a write-once or erase command (command register offset 3, bit 1 and bit 3) starts nothing, leaves the array unchanged and sets err.
- R3: A value written to the staging address register (offset 1) does not move the working pointer (offset 5) until a load command (offset 3, bit 0) is written.
- R4: Write-once programs the held data word (data register, offset 2) at the working pointer and leaves the pointer where it was.
- R5: After a write-trigger command (offset 3, bit 2), each word written to the data register is programmed at the pointer, and the pointer then advances by one word.
- R6: When the pointer advances past the last word of a page, it wraps to word 0 of the same page, and the following page is not written.
- R7: busy stays high for exactly PROG_CYCLES cycles for a program and ERASE_CYCLES cycles for an erase. The array word changes at the edge where busy falls.
- R8: wdata_ready drops in the cycle after a data-register write. It stays low while a word is held and not yet taken, and it returns high once the controller takes the word to start programming.
- R9: An erase command sets every word of the page holding the pointer to 0xFFFFFFFF and leaves other pages unchanged.
- R10: Programming stores the old word ANDed with the data, so bits can only go from 1 to 0.
- R11: A program or erase that targets a page whose protection bit is 0 changes nothing, keeps busy low and sets err.
- R12: When the lock page's own bit is 0, the lock page can be programmed or erased only while dbg_mode is 1.
- R13: Writing the status register (offset 4) with bit 2 set clears err. The same write with bit 2 clear leaves err set. Status reads busy in bit 0, wdata_ready in bit 1 and err in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_mode | input | 1 | Debug mode, lifts the lock page's own protection |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| rd_addr | input | 8 | Array read word address |
| rd_data | output | 32 | Array read data, all ones out of range |
| busy | output | 1 | An operation is running |
| wdata_ready | output | 1 | Data register is empty |
| err | output | 1 | Sticky error flag |

## Verification
The bench streams three words from the second-to-last word of a page. A design that carried the increment into the page bits would write the first word of the next page instead of wrapping. It programs the same word twice with overlapping patterns, so a controller that overwrites instead of ANDing leaves the second pattern intact. It clears the lock page's own bit and then programs it with and without dbg_mode, which exposes a guard that ignores the override or applies it to every page. It counts busy cycles for both operations and watches wdata_ready while a second word waits behind a running program, so an early release of the holding register or an off-by-one timer shows up as wrong values.

// File: rtl/flashctl_pkg.sv
`timescale 1ns/1ps
package flashctl_pkg;
  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_ADDR = 3'd1;
  localparam logic [2:0] RA_DATA = 3'd2;
  localparam logic [2:0] RA_CMD  = 3'd3;
  localparam logic [2:0] RA_STAT = 3'd4;
  localparam logic [2:0] RA_PTR  = 3'd5;

  localparam int CMD_LOAD  = 0;
  localparam int CMD_ONCE  = 1;
  localparam int CMD_TRIG  = 2;
  localparam int CMD_ERASE = 3;

  localparam int ST_BUSY = 0;
  localparam int ST_RDY  = 1;
  localparam int ST_ERR  = 2;
endpackage

// File: rtl/flashctl_array.sv
`timescale 1ns/1ps
module flashctl_array #(
  parameter int AW         = 8,
  parameter int WB         = 4,
  parameter int DEPTH      = 144,
  parameter int LOCK_BASE  = 128,
  parameter int LOCK_WORDS = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prog_en,
  input  logic                   erase_en,
  input  logic [AW-1:0]          op_addr,
  input  logic [31:0]            prog_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [31:0]            rd_data,
  output logic [LOCK_WORDS*32-1:0] lock_vec
);
  logic [31:0] words [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam logic [AW-1:0] WA = AW'(w);
    logic [31:0] word_q, word_d;
    logic        hit_pg, hit_wd;

    always_comb begin
      hit_pg = erase_en && (op_addr[AW-1:WB] == WA[AW-1:WB]);
      hit_wd = prog_en && (op_addr == WA);
      word_d = word_q;
      if (hit_pg)      word_d = '1;
      else if (hit_wd) word_d = word_q & prog_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                word_q <= '1;
      else if (hit_pg || hit_wd) word_q <= word_d;
    end

    assign words[w] = word_q;
  end

  for (genvar k = 0; k < LOCK_WORDS; k++) begin : g_lock
    assign lock_vec[k*32 +: 32] = words[LOCK_BASE + k];
  end

  assign rd_data = (int'(rd_addr) < DEPTH) ? words[rd_addr] : '1;
endmodule

// File: rtl/flashctl_guard.sv
`timescale 1ns/1ps
module flashctl_guard #(
  parameter int NUM_PAGES = 8,
  parameter int PGB       = 4,
  parameter int LOCK_BITS = 32
) (
  input  logic [PGB-1:0]       page,
  input  logic [LOCK_BITS-1:0] lock_vec,
  input  logic                 dbg_mode,
  output logic                 allowed
);
  localparam int LVB = $clog2(LOCK_BITS);

  logic [LVB-1:0] idx;
  logic           in_range, is_lock_page, bit_open;

  always_comb begin
    idx          = LVB'(page);
    in_range     = int'(page) <= NUM_PAGES;
    is_lock_page = int'(page) == NUM_PAGES;
    bit_open     = lock_vec[idx];
    allowed      = in_range && (bit_open || (is_lock_page && dbg_mode));
  end
endmodule

// File: rtl/flashctl_seq.sv
`timescale 1ns/1ps
module flashctl_seq #(
  parameter int AW           = 8,
  parameter int WB           = 4,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          cmd_load,
  input  logic          cmd_once,
  input  logic          cmd_trig,
  input  logic          cmd_erase,
  input  logic [AW-1:0] addr_buf,
  input  logic          data_full,
  input  logic [31:0]   data_reg,
  input  logic          allowed,
  output logic [AW-1:0] cur_addr,
  output logic          busy,
  output logic          consume,
  output logic          prog_en,
  output logic          erase_en,
  output logic [AW-1:0] op_addr,
  output logic [31:0]   op_data,
  output logic          err_set
);
  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [AW-1:0] cur_q, cur_d, opa_q, opa_d;
  logic [31:0]   opd_q, opd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, burst_q, burst_d;
  logic          ers_q, ers_d, inc_q, inc_d;

  always_comb begin
    cur_d = cur_q; opa_d = opa_q; opd_d = opd_q; cnt_d = cnt_q;
    busy_d = busy_q; burst_d = burst_q; ers_d = ers_q; inc_d = inc_q;
    consume = 1'b0; err_set = 1'b0; prog_en = 1'b0; erase_en = 1'b0;
    if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d   = 1'b0;
        prog_en  = !ers_q;
        erase_en = ers_q;
        if (inc_q) cur_d = {opa_q[AW-1:WB], opa_q[WB-1:0] + 1'b1};
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (cmd_load) begin
      cur_d = addr_buf; burst_d = 1'b0;
    end else if (cmd_erase) begin
      burst_d = 1'b0;
      if (!wr_en || !allowed) err_set = 1'b1;
      else begin
        busy_d = 1'b1; cnt_d = CW'(ERASE_CYCLES - 1);
        ers_d = 1'b1; inc_d = 1'b0; opa_d = cur_q;
      end
    end else if (cmd_once) begin
      burst_d = 1'b0; consume = 1'b1;
      if (!wr_en || !allowed) err_set = 1'b1;
      else begin
        busy_d = 1'b1; cnt_d = CW'(PROG_CYCLES - 1);
        ers_d = 1'b0; inc_d = 1'b0; opa_d = cur_q; opd_d = data_reg;
      end
    end else if (cmd_trig) begin
      if (!wr_en) err_set = 1'b1;
      else        burst_d = 1'b1;
    end else if (burst_q && data_full) begin
      consume = 1'b1;
      if (!allowed) err_set = 1'b1;
      else begin
        busy_d = 1'b1; cnt_d = CW'(PROG_CYCLES - 1);
        ers_d = 1'b0; inc_d = 1'b1; opa_d = cur_q; opd_d = data_reg;
      end
    end
    if (!wr_en) burst_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0; opa_q <= '0; opd_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; burst_q <= 1'b0; ers_q <= 1'b0; inc_q <= 1'b0;
    end else begin
      cur_q <= cur_d; opa_q <= opa_d; opd_q <= opd_d; cnt_q <= cnt_d;
      busy_q <= busy_d; burst_q <= burst_d; ers_q <= ers_d; inc_q <= inc_d;
    end
  end

  assign cur_addr = cur_q;
  assign busy     = busy_q;
  assign op_addr  = opa_q;
  assign op_data  = opd_q;
endmodule

// File: rtl/flashctl.sv
`timescale 1ns/1ps
module flashctl #(
  parameter int PAGE_WORDS   = 16,
  parameter int NUM_PAGES    = 8,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dbg_mode,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [$clog2(NUM_PAGES+1)+$clog2(PAGE_WORDS)-1:0] rd_addr,
  output logic [31:0] rd_data,
  output logic        busy,
  output logic        wdata_ready,
  output logic        err
);
  import flashctl_pkg::*;

  localparam int WB         = $clog2(PAGE_WORDS);
  localparam int PGB        = $clog2(NUM_PAGES + 1);
  localparam int AW         = PGB + WB;
  localparam int DEPTH      = (NUM_PAGES + 1) * PAGE_WORDS;
  localparam int LOCK_BASE  = NUM_PAGES * PAGE_WORDS;
  localparam int LOCK_WORDS = (NUM_PAGES + 32) / 32;
  localparam int LOCK_BITS  = LOCK_WORDS * 32;

  logic          ctrl_wren, wren_d;
  logic [AW-1:0] addr_buf, addr_d, cur_addr, op_addr;
  logic [31:0]   data_reg, data_d, op_data;
  logic          data_full, full_d, err_q, err_d;
  logic          we_ctrl, we_addr, we_data, we_cmd, we_stat;
  logic          consume, prog_en, erase_en, err_set, allowed;
  logic [LOCK_BITS-1:0] lock_vec;

  always_comb begin
    we_ctrl = bus_we && (bus_addr == RA_CTRL);
    we_addr = bus_we && (bus_addr == RA_ADDR);
    we_data = bus_we && (bus_addr == RA_DATA);
    we_cmd  = bus_we && (bus_addr == RA_CMD);
    we_stat = bus_we && (bus_addr == RA_STAT);
    wren_d  = we_ctrl ? bus_wdata[0] : ctrl_wren;
    addr_d  = we_addr ? bus_wdata[AW-1:0] : addr_buf;
    data_d  = we_data ? bus_wdata : data_reg;
    full_d  = we_data ? 1'b1 : (consume ? 1'b0 : data_full);
    if (err_set)                       err_d = 1'b1;
    else if (we_stat && bus_wdata[ST_ERR]) err_d = 1'b0;
    else                               err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_wren <= 1'b0; addr_buf <= '0; data_reg <= '0;
      data_full <= 1'b0; err_q <= 1'b0;
    end else begin
      if (we_ctrl) ctrl_wren <= wren_d;
      if (we_addr) addr_buf  <= addr_d;
      if (we_data) data_reg  <= data_d;
      data_full <= full_d;
      err_q     <= err_d;
    end
  end

  flashctl_seq #(.AW(AW), .WB(WB), .PROG_CYCLES(PROG_CYCLES),
                 .ERASE_CYCLES(ERASE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wren),
    .cmd_load(we_cmd && bus_wdata[CMD_LOAD]), .cmd_once(we_cmd && bus_wdata[CMD_ONCE]),
    .cmd_trig(we_cmd && bus_wdata[CMD_TRIG]), .cmd_erase(we_cmd && bus_wdata[CMD_ERASE]),
    .addr_buf(addr_buf), .data_full(data_full), .data_reg(data_reg), .allowed(allowed),
    .cur_addr(cur_addr), .busy(busy), .consume(consume), .prog_en(prog_en),
    .erase_en(erase_en), .op_addr(op_addr), .op_data(op_data), .err_set(err_set)
  );

  flashctl_guard #(.NUM_PAGES(NUM_PAGES), .PGB(PGB), .LOCK_BITS(LOCK_BITS)) u_guard (
    .page(cur_addr[AW-1:WB]), .lock_vec(lock_vec), .dbg_mode(dbg_mode), .allowed(allowed)
  );

  flashctl_array #(.AW(AW), .WB(WB), .DEPTH(DEPTH), .LOCK_BASE(LOCK_BASE),
                   .LOCK_WORDS(LOCK_WORDS)) u_array (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .erase_en(erase_en),
    .op_addr(op_addr), .prog_data(op_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .lock_vec(lock_vec)
  );

  always_comb begin
    case (bus_addr)
      RA_CTRL: bus_rdata = {31'b0, ctrl_wren};
      RA_ADDR: bus_rdata = 32'(addr_buf);
      RA_DATA: bus_rdata = data_reg;
      RA_STAT: bus_rdata = {29'b0, err_q, !data_full, busy};
      RA_PTR:  bus_rdata = 32'(cur_addr);
      default: bus_rdata = '0;
    endcase
  end

  assign wdata_ready = !data_full;
  assign err         = err_q;
endmodule

// File: rtl/flashctl_chk.sv
`timescale 1ns/1ps
module flashctl_chk #(
  parameter int AW           = 8,
  parameter int WB           = 4,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          err,
  input logic          wdata_ready,
  input logic          wr_en,
  input logic [AW-1:0] cur_addr,
  input logic          bus_we,
  input logic [2:0]    bus_addr,
  input logic [2:0]    bus_wlow
);
  logic [31:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == 32'(PROG_CYCLES) || run_cnt == 32'(ERASE_CYCLES)));

  a_r2_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  a_r3_ptr_moves_on_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_addr) |-> ($past(bus_we && bus_addr == 3'd3 && bus_wlow[0]) || $fell(busy)));

  a_r6_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$stable(cur_addr)) |-> (cur_addr[AW-1:WB] == $past(cur_addr[AW-1:WB])));

  a_r13_err_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(bus_we && bus_addr == 3'd4 && bus_wlow[2]));

  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd2) |=> !wdata_ready);
endmodule

bind flashctl flashctl_chk #(.AW(AW), .WB(WB), .PROG_CYCLES(PROG_CYCLES),
                             .ERASE_CYCLES(ERASE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .wdata_ready(wdata_ready),
  .wr_en(ctrl_wren), .cur_addr(cur_addr), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wlow(bus_wdata[2:0])
);

// File: tb/flashctl_bench.sv
`timescale 1ns/1ps
module flashctl_bench;
  localparam int PC = 8;
  localparam int EC = 20;
  localparam logic [2:0] O_CTRL = 3'd0, O_ADDR = 3'd1, O_DATA = 3'd2,
                         O_CMD = 3'd3, O_STAT = 3'd4, O_PTR = 3'd5;
  localparam logic [31:0] C_LOAD = 32'h1, C_ONCE = 32'h2, C_TRIG = 32'h4, C_ERASE = 32'h8;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n, dbg_mode, bus_we;
  logic [2:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, rd_data;
  logic [7:0] rd_addr;
  logic busy, wdata_ready, err;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flashctl u_flashctl (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .wdata_ready(wdata_ready), .err(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic mem_rd(input int a, output logic [31:0] d);
    rd_addr = 8'(a); #0.5; d = rd_data;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 1000) begin cyc++; @(negedge clk); end
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 1000 && (busy || !wdata_ready); i++) @(negedge clk);
  endtask

  task automatic point(input int a);
    bus_wr(O_ADDR, 32'(a));
    bus_wr(O_CMD, C_LOAD);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 ready", 32'(wdata_ready), 32'd1);
    check("R1 err", 32'(err), 32'd0);
    bus_rd(O_PTR, v); check("R1 pointer", v, 32'd0);
    mem_rd(0, v);   check("R1 word0", v, ONES);
    mem_rd(143, v); check("R1 lock word last", v, ONES);
  endtask

  task automatic t_load();
    logic [31:0] v;
    bus_wr(O_ADDR, 32'd5);
    bus_rd(O_PTR, v); check("R3 pointer before load", v, 32'd0);
    bus_wr(O_CMD, C_LOAD);
    bus_rd(O_PTR, v); check("R3 pointer after load", v, 32'd5);
  endtask

  task automatic t_wren();
    logic [31:0] v;
    bus_wr(O_DATA, 32'h0);
    bus_wr(O_CMD, C_ONCE);
    check("R2 err set without enable", 32'(err), 32'd1);
    check("R2 no busy without enable", 32'(busy), 32'd0);
    repeat (PC + 2) @(negedge clk);
    mem_rd(5, v); check("R2 word untouched", v, ONES);
    bus_wr(O_STAT, 32'h0);
    check("R13 err kept on bit2 clear", 32'(err), 32'd1);
    bus_wr(O_STAT, 32'h4);
    check("R13 err cleared", 32'(err), 32'd0);
  endtask

  task automatic t_once();
    logic [31:0] v; int cyc;
    bus_wr(O_CTRL, 32'h1);
    bus_wr(O_DATA, 32'hF0F0_FF00);
    bus_wr(O_CMD, C_ONCE);
    wait_idle(cyc);
    check("R7 program busy cycles", 32'(cyc), 32'(PC));
    mem_rd(5, v); check("R4 word programmed", v, 32'hF0F0_FF00);
    bus_rd(O_PTR, v); check("R4 pointer unchanged", v, 32'd5);
    bus_wr(O_DATA, 32'h0FF0_F0F0);
    bus_wr(O_CMD, C_ONCE);
    wait_idle(cyc);
    mem_rd(5, v); check("R10 AND of old and new", v, 32'h00F0_F000);
  endtask

  task automatic t_burst();
    logic [31:0] v;
    point(30);
    bus_wr(O_CMD, C_TRIG);
    bus_wr(O_DATA, 32'hA5A5_0001);
    check("R8 ready low after data write", 32'(wdata_ready), 32'd0);
    bus_wr(O_DATA, 32'h5A5A_0002);
    check("R8 busy with second word held", 32'(busy), 32'd1);
    check("R8 ready low while word waits", 32'(wdata_ready), 32'd0);
    wait_drain();
    check("R8 ready high when drained", 32'(wdata_ready), 32'd1);
    bus_wr(O_DATA, 32'h3C3C_0003);
    wait_drain();
    mem_rd(30, v); check("R5 first burst word", v, 32'hA5A5_0001);
    mem_rd(31, v); check("R5 second burst word", v, 32'h5A5A_0002);
    mem_rd(16, v); check("R6 wrapped to page start", v, 32'h3C3C_0003);
    mem_rd(32, v); check("R6 next page untouched", v, ONES);
    bus_rd(O_PTR, v); check("R5 pointer advanced", v, 32'd17);
  endtask

  task automatic t_erase();
    logic [31:0] v; int cyc;
    point(20);
    bus_wr(O_CMD, C_ERASE);
    wait_idle(cyc);
    check("R7 erase busy cycles", 32'(cyc), 32'(EC));
    mem_rd(16, v); check("R9 erased first word", v, ONES);
    mem_rd(30, v); check("R9 erased word 14", v, ONES);
    mem_rd(31, v); check("R9 erased last word", v, ONES);
    mem_rd(5, v);  check("R9 other page kept", v, 32'h00F0_F000);
  endtask

  task automatic t_lock();
    logic [31:0] v; int cyc;
    point(128);
    bus_wr(O_DATA, 32'hFFFF_FFFB);
    bus_wr(O_CMD, C_ONCE);
    wait_idle(cyc);
    mem_rd(128, v); check("R11 page 2 protection cleared", v, 32'hFFFF_FFFB);
    point(40);
    bus_wr(O_DATA, 32'h0);
    bus_wr(O_CMD, C_ONCE);
    check("R11 err on locked program", 32'(err), 32'd1);
    check("R11 no busy on locked program", 32'(busy), 32'd0);
    repeat (PC + 2) @(negedge clk);
    mem_rd(40, v); check("R11 locked word kept", v, ONES);
    bus_wr(O_STAT, 32'h4);
    bus_wr(O_CMD, C_ERASE);
    check("R11 err on locked erase", 32'(err), 32'd1);
    check("R11 no busy on locked erase", 32'(busy), 32'd0);
    bus_wr(O_STAT, 32'h4);
  endtask

  task automatic t_lockpage();
    logic [31:0] v; int cyc;
    point(128);
    bus_wr(O_DATA, 32'hFFFF_FEFF);
    bus_wr(O_CMD, C_ONCE);
    wait_idle(cyc);
    mem_rd(128, v); check("R12 own bit cleared", v, 32'hFFFF_FEFB);
    bus_wr(O_DATA, 32'hFFFF_FFF0);
    bus_wr(O_CMD, C_ONCE);
    check("R12 err without debug", 32'(err), 32'd1);
    repeat (PC + 2) @(negedge clk);
    mem_rd(128, v); check("R12 lock page kept without debug", v, 32'hFFFF_FEFB);
    bus_wr(O_STAT, 32'h4);
    dbg_mode = 1'b1;
    bus_wr(O_DATA, 32'hFFFF_FFF0);
    bus_wr(O_CMD, C_ONCE);
    wait_idle(cyc);
    mem_rd(128, v); check("R12 lock page written in debug", v, 32'hFFFF_FEF0);
    check("R12 no err in debug", 32'(err), 32'd0);
    bus_wr(O_CMD, C_ERASE);
    wait_idle(cyc);
    mem_rd(128, v); check("R12 lock page erased in debug", v, ONES);
    dbg_mode = 1'b0;
    point(40);
    bus_wr(O_DATA, 32'h1234_5678);
    bus_wr(O_CMD, C_ONCE);
    wait_idle(cyc);
    mem_rd(40, v); check("R11 page 2 open after lock erase", v, 32'h1234_5678);
    check("R11 no err when open", 32'(err), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; dbg_mode = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_wren();
    t_once();
    t_burst();
    t_erase();
    t_lock();
    t_lockpage();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule